// File: doc/BRIEF.md
# DMA Channel Control Register File

This block holds the software-visible control state of a multi-channel DMA engine that feeds network ports. A processor reaches it over a synchronous register port addressed by register number. One strobe writes. A second strobe reads, and the data comes back one cycle later. The block stores the following:

- a configuration word and an error status word
- an interrupt enable mask
- set and reset words for the active transmit and receive channels
- four interrupt status words: end-of-buffer and descriptor-error, for each direction
- per-channel descriptor table pointers for transmit and for receive
- per-channel buffer sizes for receive

The numbers of transmit and receive channels are parameters, from 1 to 32. Each per-channel register group sits in an address window at a fixed base, and the window is exactly as long as its channel count. The status words are cleared by writing ones. The engine's datapath sets status bits through dedicated set inputs. Writing the configuration word with its top bit high performs a soft reset of the control state. The same write then stores its own masked value into the configuration word.

Top module: `dmareg_file`

## Requirements
- R1: After reset, configuration reads 0x0007C000. Every other register reads zero, including all pointer and buffer-size entries.
- R2: A read strobe in one cycle presents the addressed value on the read data output in the next cycle. The output holds that value until the next read strobe. Unlisted register numbers read as zero.
- R3: Writes are masked as follows: interrupt enable (0x182) keeps bits 4:0. Transmit set (0x184) and transmit reset (0x185) keep bits 31:28. Receive set (0x190) and receive reset (0x191) keep bits 31:30.
- R4: These five status words are write-one-to-clear: error status 0x181, transmit end-of-buffer 0x186, transmit descriptor error 0x187, receive end-of-buffer 0x192, receive descriptor error 0x193. A written one clears that bit and a written zero leaves it unchanged.
- R5: A hardware set input bit that is high in the same cycle as a software clear of that bit leaves the bit set.
- R6: A write to configuration (0x180) with bit 31 high has these effects. Interrupt enable, both set words and all five status words return to zero. Configuration then holds the written value ANDed with 0x00FFC087. A configuration write with bit 31 low only stores the masked value.
- R7: Transmit descriptor pointers live at 0x1A0+i and receive descriptor pointers at 0x1C0+i. Both store all 32 bits. Receive buffer sizes live at 0x1E0+i and keep bits 7:0. Each window covers only its channel count. Numbers beyond a window read zero and ignore writes. Counts above 32 are rejected at elaboration.
- R8: A write to a register number outside the fixed list and outside every window changes no register.
- R9: A soft reset leaves the transmit and receive reset words, all descriptor pointers and all buffer sizes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 10 | Register number |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| hw_err_set | input | 32 | Hardware set bits for error status |
| hw_tx_eob_set | input | 32 | Hardware set bits for transmit end-of-buffer status |
| hw_tx_derr_set | input | 32 | Hardware set bits for transmit descriptor-error status |
| hw_rx_eob_set | input | 32 | Hardware set bits for receive end-of-buffer status |
| hw_rx_derr_set | input | 32 | Hardware set bits for receive descriptor-error status |

## Verification
Two updates can land on the same status bit in one cycle: a software write-one-to-clear and a hardware set. The bench provokes this by raising a set input on exactly the clock edge that carries the clearing write to the transmit end-of-buffer word. It then reads the word back. The bit must still be set, while the cleared bits that had no set must be gone. A soft reset that coincides with the storing of the new configuration value is judged in the same way. The checks cover the masked configuration value, the zeroed control words, and the preserved pointers and reset words.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    localparam int REG_AW = 10;
    localparam int REG_DW = 32;
    localparam int MAX_CHANS = 32;
    localparam int NUM_STS = 5;

    // fixed register numbers
    localparam logic [REG_AW-1:0] A_CFG    = 10'h180;
    localparam logic [REG_AW-1:0] A_ERR    = 10'h181;
    localparam logic [REG_AW-1:0] A_IEN    = 10'h182;
    localparam logic [REG_AW-1:0] A_TXSET  = 10'h184;
    localparam logic [REG_AW-1:0] A_TXRST  = 10'h185;
    localparam logic [REG_AW-1:0] A_TXEOB  = 10'h186;
    localparam logic [REG_AW-1:0] A_TXDERR = 10'h187;
    localparam logic [REG_AW-1:0] A_RXSET  = 10'h190;
    localparam logic [REG_AW-1:0] A_RXRST  = 10'h191;
    localparam logic [REG_AW-1:0] A_RXEOB  = 10'h192;
    localparam logic [REG_AW-1:0] A_RXDERR = 10'h193;

    // window bases
    localparam logic [REG_AW-1:0] B_TXPTR  = 10'h1A0;
    localparam logic [REG_AW-1:0] B_RXPTR  = 10'h1C0;
    localparam logic [REG_AW-1:0] B_RXBSZ  = 10'h1E0;

    // write masks and reset values
    localparam logic [REG_DW-1:0] M_CFG    = 32'h00FF_C087;
    localparam logic [REG_DW-1:0] M_IEN    = 32'h0000_001F;
    localparam logic [REG_DW-1:0] M_TXACT  = 32'hF000_0000;
    localparam logic [REG_DW-1:0] M_RXACT  = 32'hC000_0000;
    localparam logic [REG_DW-1:0] M_BSZ    = 32'h0000_00FF;
    localparam logic [REG_DW-1:0] M_FULL   = 32'hFFFF_FFFF;
    localparam logic [REG_DW-1:0] CFG_RST  = 32'h0007_C000;
    localparam int                CFG_SOFT = 31;

    // status word slots, order used by the generate loop in the top
    typedef enum logic [2:0] {
        ST_ERR    = 3'd0,
        ST_TXEOB  = 3'd1,
        ST_TXDERR = 3'd2,
        ST_RXEOB  = 3'd3,
        ST_RXDERR = 3'd4
    } sts_slot_e;

    localparam logic [REG_AW-1:0] STS_ADDR [NUM_STS] =
        '{A_ERR, A_TXEOB, A_TXDERR, A_RXEOB, A_RXDERR};

    typedef struct packed {
        logic [REG_DW-1:0] cfg;
        logic [REG_DW-1:0] ien;
        logic [REG_DW-1:0] txset;
        logic [REG_DW-1:0] txrst;
        logic [REG_DW-1:0] rxset;
        logic [REG_DW-1:0] rxrst;
        logic [REG_DW-1:0] rdata;
    } ctl_t;

endpackage

// File: rtl/dmareg_sts.sv
module dmareg_sts #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);

    logic [W-1:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (soft_clr) begin
            st_d = '0;
        end else if (clr_we) begin
            st_d = st_q & ~clr_mask;
        end
        // hardware set wins over any clear in the same cycle
        st_d = st_d | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q;

    // R4: cleared bits are gone unless hardware set them again
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !soft_clr) |=> ((q & $past(clr_mask) & ~$past(hw_set)) == '0));

    // R5: a set always lands, whatever else happens that cycle
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((q & $past(hw_set)) == $past(hw_set)));

    // R4: with no set and no clear the word holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we && !soft_clr && hw_set == '0) |=> $stable(q));

endmodule

// File: rtl/dmareg_chan_bank.sv
module dmareg_chan_bank #(
    parameter int              NCH  = 4,
    parameter int              AW   = 10,
    parameter int              DW   = 32,
    parameter logic [AW-1:0]   BASE = '0,
    parameter logic [DW-1:0]   KEEP = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          hit,
    output logic [DW-1:0] rd_val
);

    localparam int MAXN = 32;

    logic [NCH-1:0]         sel;
    logic [NCH-1:0][DW-1:0] bank_d, bank_q;

    for (genvar c = 0; c < NCH; c++) begin : g_sel
        assign sel[c] = (addr == AW'(int'(BASE) + c));
    end

    assign hit = |sel;

    always_comb begin
        bank_d = bank_q;
        rd_val = '0;
        for (int c = 0; c < NCH; c++) begin
            if (wr && sel[c]) bank_d[c] = wdata & KEEP;
            if (sel[c])       rd_val    = bank_q[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    // R7: window length must be 1..32
    initial begin : a_r7_chan_limit
        assert (NCH >= 1 && NCH <= MAXN)
            else $error("channel count %0d outside 1..%0d", NCH, MAXN);
    end

    // R7: a write outside this window leaves every entry untouched
    a_r7_outside_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !hit) |=> $stable(bank_q));

    // R7: at most one entry decodes
    a_r7_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

endmodule

// File: rtl/dmareg_file.sv
module dmareg_file
    import dmareg_pkg::*;
#(
    parameter int TX_CHANS = 4,
    parameter int RX_CHANS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [9:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] hw_err_set,
    input  logic [31:0] hw_tx_eob_set,
    input  logic [31:0] hw_tx_derr_set,
    input  logic [31:0] hw_rx_eob_set,
    input  logic [31:0] hw_rx_derr_set
);

    ctl_t ctl_d, ctl_q;

    logic              soft_rst;
    logic              fixed_hit;
    logic              any_hit;
    logic [REG_DW-1:0] rd_mux;

    logic [REG_DW-1:0] sts_hw [NUM_STS];
    logic [REG_DW-1:0] sts_q  [NUM_STS];
    logic [NUM_STS-1:0] sts_hit;

    logic              txp_hit, rxp_hit, bsz_hit;
    logic [REG_DW-1:0] txp_val, rxp_val, bsz_val;

    assign soft_rst = reg_wr && (reg_addr == A_CFG) && reg_wdata[CFG_SOFT];

    assign sts_hw[ST_ERR]    = hw_err_set;
    assign sts_hw[ST_TXEOB]  = hw_tx_eob_set;
    assign sts_hw[ST_TXDERR] = hw_tx_derr_set;
    assign sts_hw[ST_RXEOB]  = hw_rx_eob_set;
    assign sts_hw[ST_RXDERR] = hw_rx_derr_set;

    // write-one-to-clear status words
    for (genvar s = 0; s < NUM_STS; s++) begin : g_sts
        assign sts_hit[s] = (reg_addr == STS_ADDR[s]);
        dmareg_sts #(.W(REG_DW)) u_sts (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_clr (soft_rst),
            .clr_we   (reg_wr && sts_hit[s]),
            .clr_mask (reg_wdata),
            .hw_set   (sts_hw[s]),
            .q        (sts_q[s])
        );
    end

    // per-channel windows
    dmareg_chan_bank #(.NCH(TX_CHANS), .AW(REG_AW), .DW(REG_DW),
                       .BASE(B_TXPTR), .KEEP(M_FULL)) u_txptr (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
        .wdata(reg_wdata), .hit(txp_hit), .rd_val(txp_val)
    );

    dmareg_chan_bank #(.NCH(RX_CHANS), .AW(REG_AW), .DW(REG_DW),
                       .BASE(B_RXPTR), .KEEP(M_FULL)) u_rxptr (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
        .wdata(reg_wdata), .hit(rxp_hit), .rd_val(rxp_val)
    );

    dmareg_chan_bank #(.NCH(RX_CHANS), .AW(REG_AW), .DW(REG_DW),
                       .BASE(B_RXBSZ), .KEEP(M_BSZ)) u_rxbsz (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
        .wdata(reg_wdata), .hit(bsz_hit), .rd_val(bsz_val)
    );

    // read selection
    always_comb begin
        fixed_hit = 1'b1;
        unique case (reg_addr)
            A_CFG:    rd_mux = ctl_q.cfg;
            A_IEN:    rd_mux = ctl_q.ien;
            A_TXSET:  rd_mux = ctl_q.txset;
            A_TXRST:  rd_mux = ctl_q.txrst;
            A_RXSET:  rd_mux = ctl_q.rxset;
            A_RXRST:  rd_mux = ctl_q.rxrst;
            A_ERR:    rd_mux = sts_q[ST_ERR];
            A_TXEOB:  rd_mux = sts_q[ST_TXEOB];
            A_TXDERR: rd_mux = sts_q[ST_TXDERR];
            A_RXEOB:  rd_mux = sts_q[ST_RXEOB];
            A_RXDERR: rd_mux = sts_q[ST_RXDERR];
            default: begin
                fixed_hit = 1'b0;
                rd_mux    = txp_val | rxp_val | bsz_val;
            end
        endcase
    end

    assign any_hit = fixed_hit || txp_hit || rxp_hit || bsz_hit;

    // next state of the control words
    always_comb begin
        ctl_d = ctl_q;
        if (soft_rst) begin
            ctl_d.ien   = '0;
            ctl_d.txset = '0;
            ctl_d.rxset = '0;
        end
        if (reg_wr) begin
            unique case (reg_addr)
                A_CFG:   ctl_d.cfg   = reg_wdata & M_CFG;
                A_IEN:   ctl_d.ien   = reg_wdata & M_IEN;
                A_TXSET: ctl_d.txset = reg_wdata & M_TXACT;
                A_TXRST: ctl_d.txrst = reg_wdata & M_TXACT;
                A_RXSET: ctl_d.rxset = reg_wdata & M_RXACT;
                A_RXRST: ctl_d.rxrst = reg_wdata & M_RXACT;
                default: ;
            endcase
        end
        if (reg_rd) ctl_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.cfg   <= CFG_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign reg_rdata = ctl_q.rdata;

    // R2: read data holds between read strobes
    a_r2_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

    // R2: unlisted numbers read back zero
    a_r2_unlisted_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !any_hit) |=> (reg_rdata == '0));

    // R6: a soft reset zeroes enable and set words
    a_r6_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ctl_q.ien == '0 && ctl_q.txset == '0 && ctl_q.rxset == '0));

    // R6: configuration keeps the masked written value
    a_r6_cfg_store: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CFG) |=> (ctl_q.cfg == ($past(reg_wdata) & M_CFG)));

    // R9: soft reset spares the reset words
    a_r9_soft_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> ($stable(ctl_q.txrst) && $stable(ctl_q.rxrst)));

    // R8: unlisted writes change no control word
    a_r8_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !any_hit) |=> ($stable(ctl_q.cfg) && $stable(ctl_q.ien) &&
                                  $stable(ctl_q.txset) && $stable(ctl_q.txrst) &&
                                  $stable(ctl_q.rxset) && $stable(ctl_q.rxrst)));

endmodule

// File: tb/dmareg_file_tb.sv
module dmareg_file_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] hw_err_set = '0;
    logic [31:0] hw_tx_eob_set = '0;
    logic [31:0] hw_tx_derr_set = '0;
    logic [31:0] hw_rx_eob_set = '0;
    logic [31:0] hw_rx_derr_set = '0;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    dmareg_file #(.TX_CHANS(4), .RX_CHANS(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hw_err_set(hw_err_set), .hw_tx_eob_set(hw_tx_eob_set),
        .hw_tx_derr_set(hw_tx_derr_set), .hw_rx_eob_set(hw_rx_eob_set),
        .hw_rx_derr_set(hw_rx_derr_set)
    );

    typedef struct packed {
        logic        is_rd;
        logic [3:0]  req;
        logic [9:0]  addr;
        logic [31:0] val;
    } vec_t;

    localparam int NVEC = 30;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 4'd3, 10'h182, 32'hFFFF_FFFF}, '{1'b1, 4'd3, 10'h182, 32'h0000_001F}, // R3
        '{1'b0, 4'd3, 10'h184, 32'hFFFF_FFFF}, '{1'b1, 4'd3, 10'h184, 32'hF000_0000},
        '{1'b0, 4'd3, 10'h185, 32'h1234_5678}, '{1'b1, 4'd3, 10'h185, 32'h1000_0000},
        '{1'b0, 4'd3, 10'h190, 32'hFFFF_FFFF}, '{1'b1, 4'd3, 10'h190, 32'hC000_0000},
        '{1'b0, 4'd3, 10'h191, 32'h7FFF_FFFF}, '{1'b1, 4'd3, 10'h191, 32'h4000_0000},
        '{1'b0, 4'd7, 10'h1A0, 32'hDEAD_BEEF}, '{1'b1, 4'd7, 10'h1A0, 32'hDEAD_BEEF}, // R7
        '{1'b0, 4'd7, 10'h1A3, 32'h0102_0304}, '{1'b1, 4'd7, 10'h1A3, 32'h0102_0304},
        '{1'b0, 4'd7, 10'h1A4, 32'h0000_AAAA}, '{1'b1, 4'd7, 10'h1A4, 32'h0000_0000},
        '{1'b0, 4'd7, 10'h1C1, 32'h55AA_55AA}, '{1'b1, 4'd7, 10'h1C1, 32'h55AA_55AA},
        '{1'b0, 4'd7, 10'h1C2, 32'h0000_1111}, '{1'b1, 4'd7, 10'h1C2, 32'h0000_0000},
        '{1'b0, 4'd7, 10'h1E0, 32'h0000_1234}, '{1'b1, 4'd7, 10'h1E0, 32'h0000_0034},
        '{1'b1, 4'd7, 10'h1E2, 32'h0000_0000},
        '{1'b0, 4'd8, 10'h183, 32'h0000_FFFF}, '{1'b1, 4'd8, 10'h183, 32'h0000_0000}, // R8
        '{1'b1, 4'd2, 10'h000, 32'h0000_0000},                                         // R2
        '{1'b0, 4'd6, 10'h180, 32'h7FFF_FFFF}, '{1'b1, 4'd6, 10'h180, 32'h00FF_C087}, // R6
        '{1'b0, 4'd6, 10'h180, 32'h0000_FFFF}, '{1'b1, 4'd6, 10'h180, 32'h0000_C087}
    };

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic rd_check(input int req, input logic [9:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_check(1, 10'h180, 32'h0007_C000);
        rd_check(1, 10'h182, 32'h0);
        rd_check(1, 10'h181, 32'h0);
        rd_check(1, 10'h186, 32'h0);
        rd_check(1, 10'h184, 32'h0);
        rd_check(1, 10'h1A0, 32'h0);
        rd_check(1, 10'h1E1, 32'h0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].is_rd) rd_check(int'(VEC[i].req), VEC[i].addr, VEC[i].val);
            else              wr(VEC[i].addr, VEC[i].val);
        end

        // R4: hardware set then write-one-to-clear
        @(negedge clk); hw_tx_eob_set = 32'h0000_F0F0;
        @(negedge clk); hw_tx_eob_set = '0;
        rd_check(4, 10'h186, 32'h0000_F0F0);
        wr(10'h186, 32'h0000_00F0);
        rd_check(4, 10'h186, 32'h0000_F000);
        wr(10'h186, 32'h0000_0000);
        rd_check(4, 10'h186, 32'h0000_F000);

        // R5: set and clear of one bit in the same cycle
        @(negedge clk);
        reg_addr = 10'h186; reg_wdata = 32'h0000_F000; reg_wr = 1'b1;
        hw_tx_eob_set = 32'h0000_1000;
        @(negedge clk);
        reg_wr = 1'b0; hw_tx_eob_set = '0;
        rd_check(5, 10'h186, 32'h0000_1000);

        // R6 / R9: soft reset
        wr(10'h182, 32'h0000_001F);
        wr(10'h184, 32'hF000_0000);
        @(negedge clk); hw_err_set = 32'h3; hw_rx_derr_set = 32'hFF;
        @(negedge clk); hw_err_set = '0;    hw_rx_derr_set = '0;
        rd_check(4, 10'h193, 32'h0000_00FF);
        wr(10'h180, 32'h80FF_FFFF);
        rd_check(6, 10'h180, 32'h00FF_C087);
        rd_check(6, 10'h182, 32'h0);
        rd_check(6, 10'h181, 32'h0);
        rd_check(6, 10'h193, 32'h0);
        rd_check(6, 10'h186, 32'h0);
        rd_check(6, 10'h184, 32'h0);
        rd_check(6, 10'h190, 32'h0);
        rd_check(9, 10'h185, 32'h1000_0000);
        rd_check(9, 10'h191, 32'h4000_0000);
        rd_check(9, 10'h1A0, 32'hDEAD_BEEF);
        rd_check(9, 10'h1E0, 32'h0000_0034);

        // R2: read data holds until the next read strobe
        rd(10'h182, d);
        check(2, d, 32'h0);
        wr(10'h182, 32'h0000_0005);
        repeat (2) @(negedge clk);
        check(2, reg_rdata, 32'h0);
        rd_check(2, 10'h182, 32'h0000_0005);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule